// File: doc/BRIEF.md
# Prioritized Interrupt Identification Unit

This block holds the interrupt-enable bits of a legacy serial port and works out which single interrupt reason the port reports. Four conditions compete for the report: an overrun on the receive line, received data waiting, a transmit-empty event that is still pending, and a modem-line change. The winner is returned as a reason code in the low nibble of the identification byte. The top two bits of that byte show whether the receive queue is enabled. A level interrupt request follows the reason and goes high whenever any reason is pending.

The transmit-empty condition is not a live input. It is a sticky flag held by a small two-state machine with the states `TXE_IDLE` and `TXE_PEND`. The transition ARM (`TXE_IDLE`→`TXE_PEND`) happens on any data-register write. The transition CONSUME (`TXE_PEND`→`TXE_IDLE`) happens only when an identification read reports transmit-empty as its reason. The transition REARM keeps the machine in `TXE_PEND` when a consuming read and a data write arrive in the same cycle. In every other case the machine holds its state. The identification byte is combinational, so a read returns the reason that was valid in that cycle. The request output is registered from the state as it will be after the clock edge.

Top module: `irq_ident_unit`

## Requirements
- R1: An enable write stores only bits 3:0 of the byte (bit 0 receive data, bit 1 transmit empty, bit 2 line status, bit 3 modem status). Bits 7:4 of the written byte have no effect on the reported reason.
- R2: When overrun is high and enable bit 2 is set, the reason code is 0x6, whatever the other conditions are.
- R3: Otherwise, when received data is present and enable bit 0 is set, the reason code is 0xC.
- R4: Otherwise, when the transmit-empty flag is pending and enable bit 1 is set, the reason code is 0x2.
- R5: Otherwise, when a modem change is pending and enable bit 3 is set, the reason code is 0x0. If no condition applies, the code is 0x1.
- R6: Every data-register write makes the transmit-empty flag pending. The flag stays pending while its enable is clear.
- R7: An identification read clears the pending flag only when that read reports code 0x2. A read that reports any other code leaves the flag pending.
- R8: A data write in the same cycle as a clearing read leaves the flag pending.
- R9: Identification byte bits 7:6 are 11 when the queue-enable input is high and 00 otherwise. Bits 5:4 are 0, and bits 3:0 carry the reason code.
- R10: The request is a registered level. It changes at the first clock edge after the event that changes the reason and is high exactly when the reason is not 0x1.
- R11: After reset the enables are 0, the flag is not pending, the request is low and the reason code is 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Byte written to the enable register |
| overrun | input | 1 | Receive overrun flag |
| rx_present | input | 1 | At least one received character waiting |
| data_wr | input | 1 | Data-register write strobe |
| modem_delta | input | 1 | Some modem change bit pending |
| queue_en | input | 1 | Receive queue enabled |
| id_rd | input | 1 | Identification-register read strobe |
| id_byte | output | 8 | Identification byte (queue bits and reason code) |
| irq | output | 1 | Registered level interrupt request |

## Verification
Two events can land on the flag in the same cycle: the consuming read clears it and a data write sets it. The bench provokes this by asserting the read strobe and the data write together while transmit-empty is the reported reason. It then expects the flag to stay pending, which shows up as code 0x2 after the clock edge. A second same-cycle case pairs an enable write with a data write, and the bench checks that the masked flag is not lost. A reference model in the bench computes both the byte returned before the edge and the byte after it.

// File: rtl/irq_id_pkg.sv
package irq_id_pkg;
    localparam int ENABLE_W = 4;
    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    typedef enum logic [3:0] {
        RSN_MODEM = 4'h0,
        RSN_NONE  = 4'h1,
        RSN_TXE   = 4'h2,
        RSN_LINE  = 4'h6,
        RSN_RXTMO = 4'hC
    } reason_e;

    typedef enum logic {
        TXE_IDLE = 1'b0,
        TXE_PEND = 1'b1
    } txe_state_e;
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int REG_W = 8,
    parameter int EN_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [EN_W-1:0]  en_q,
    output logic [EN_W-1:0]  en_d
);
    always_comb begin
        en_d = en_q;
        if (we) en_d = wdata[EN_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assert_store_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> en_q == $past(wdata[EN_W-1:0]));
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(en_q));
endmodule

// File: rtl/txe_tracker.sv
module txe_tracker
    import irq_id_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic data_wr,
    input  logic id_rd,
    input  logic tx_reported,
    output logic pending,
    output logic pending_next
);
    txe_state_e state_q, state_d;

    // ARM: IDLE->PEND on data write; CONSUME: PEND->IDLE on reporting read;
    // REARM: PEND held when both happen together.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXE_IDLE: if (data_wr) state_d = TXE_PEND;
            TXE_PEND: if (id_rd && tx_reported && !data_wr) state_d = TXE_IDLE;
            default:  state_d = TXE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TXE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pending      = (state_q == TXE_PEND);
        pending_next = (state_d == TXE_PEND);
    end

    assert_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> pending);
    assert_consume_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rd && tx_reported && !data_wr) |=> !pending);
    assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !(id_rd && tx_reported)) |=> pending);
    assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rd && tx_reported && data_wr) |=> pending);
endmodule

// File: rtl/irq_prioritizer.sv
module irq_prioritizer
    import irq_id_pkg::*;
#(
    parameter int EN_W = ENABLE_W
) (
    input  logic [EN_W-1:0] en,
    input  logic            line_err,
    input  logic            rx_ready,
    input  logic            txe_pending,
    input  logic            modem_chg,
    output reason_e         reason
);
    always_comb begin
        if (line_err && en[EN_LINE])          reason = RSN_LINE;
        else if (rx_ready && en[EN_RX])       reason = RSN_RXTMO;
        else if (txe_pending && en[EN_TX])    reason = RSN_TXE;
        else if (modem_chg && en[EN_MODEM])   reason = RSN_MODEM;
        else                                  reason = RSN_NONE;
    end
endmodule

// File: rtl/irq_ident_unit.sv
module irq_ident_unit
    import irq_id_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic [DATA_W-1:0] en_wdata,
    input  logic              overrun,
    input  logic              rx_present,
    input  logic              data_wr,
    input  logic              modem_delta,
    input  logic              queue_en,
    input  logic              id_rd,
    output logic [DATA_W-1:0] id_byte,
    output logic              irq
);
    localparam int QBITS = 2;
    localparam int PAD_W = DATA_W - QBITS - 4;

    logic [ENABLE_W-1:0] en_q, en_d;
    logic                pend_q, pend_d;
    reason_e             rsn_now, rsn_next;
    logic                irq_q;

    irq_enable_reg #(.REG_W(DATA_W), .EN_W(ENABLE_W)) u_en (
        .clk(clk), .rst_n(rst_n), .we(en_wr), .wdata(en_wdata),
        .en_q(en_q), .en_d(en_d)
    );

    irq_prioritizer #(.EN_W(ENABLE_W)) u_pri_now (
        .en(en_q), .line_err(overrun), .rx_ready(rx_present),
        .txe_pending(pend_q), .modem_chg(modem_delta), .reason(rsn_now)
    );

    txe_tracker u_txe (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .id_rd(id_rd),
        .tx_reported(rsn_now == RSN_TXE),
        .pending(pend_q), .pending_next(pend_d)
    );

    irq_prioritizer #(.EN_W(ENABLE_W)) u_pri_next (
        .en(en_d), .line_err(overrun), .rx_ready(rx_present),
        .txe_pending(pend_d), .modem_chg(modem_delta), .reason(rsn_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (rsn_next != RSN_NONE);
    end

    always_comb begin
        id_byte = {{QBITS{queue_en}}, {PAD_W{1'b0}}, rsn_now};
        irq     = irq_q;
    end

    assert_line_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && en_q[EN_LINE]) |-> id_byte[3:0] == 4'h6);
    assert_qbits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        id_byte[DATA_W-1:DATA_W-2] == {2{queue_en}} && id_byte[5:4] == 2'b00);
    assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);
    assert_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $stable({en_wr, overrun, rx_present, data_wr, modem_delta, id_rd}) && !en_wr
            && !data_wr && !id_rd && $past(!en_wr && !data_wr && !id_rd)
            |-> irq == (id_byte[3:0] != 4'h1));
endmodule

// File: tb/tb_irq_ident_unit.sv
module tb_irq_ident_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_wr = 0, overrun = 0, rx_present = 0, data_wr = 0;
    logic       modem_delta = 0, queue_en = 0, id_rd = 0;
    logic [7:0] en_wdata = 0;
    logic [7:0] id_byte;
    logic       irq;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    logic [8:0] q_exp[$];
    string      q_tag[$];

    logic [3:0] m_en = 0;
    logic       m_pend = 0;
    logic       m_irq = 0;

    always #5 clk = ~clk;

    irq_ident_unit dut (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
        .overrun(overrun), .rx_present(rx_present), .data_wr(data_wr),
        .modem_delta(modem_delta), .queue_en(queue_en), .id_rd(id_rd),
        .id_byte(id_byte), .irq(irq)
    );

    function automatic logic [3:0] ref_reason(logic [3:0] en, logic pend,
                                              logic ov, logic rx, logic md);
        if (ov && en[2])        return 4'h6;
        else if (rx && en[0])   return 4'hC;
        else if (pend && en[1]) return 4'h2;
        else if (md && en[3])   return 4'h0;
        else                    return 4'h1;
    endfunction

    task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual irq/id=%h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected post-edge results
    always @(negedge clk) begin
        if (!done && q_exp.size() > 0) begin
            automatic logic [8:0] e = q_exp.pop_front();
            automatic string t = q_tag.pop_front();
            check(t, {irq, id_byte}, e);
        end
    end

    task automatic step(string tag, logic ew, logic [7:0] wd, logic ov,
                        logic rx, logic dw, logic md, logic fe, logic rd);
        logic [3:0] r;
        logic [7:0] pre;
        @(negedge clk);
        #1;
        en_wr = ew; en_wdata = wd; overrun = ov; rx_present = rx;
        data_wr = dw; modem_delta = md; queue_en = fe; id_rd = rd;
        #1;
        r = ref_reason(m_en, m_pend, ov, rx, md);
        pre = {fe, fe, 2'b00, r};
        check({"R10 pre ", tag}, {irq, id_byte}, {m_irq, pre});
        if (rd && r == 4'h2) m_pend = 0;
        if (dw) m_pend = 1;
        if (ew) m_en = wd[3:0];
        r = ref_reason(m_en, m_pend, ov, rx, md);
        m_irq = (r != 4'h1);
        q_exp.push_back({m_irq, fe, fe, 2'b00, r});
        q_tag.push_back(tag);
    endtask

    initial begin
        #200000;
        bad++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #23;
        check("R11 reset", {irq, id_byte}, 9'h001);
        rst_n = 1'b1;
        step("R11 idle",            0, 8'h00, 0, 0, 0, 0, 0, 0);
        step("R1 upper bits",       1, 8'hF0, 1, 1, 0, 1, 0, 0);
        step("R1 hold",             0, 8'h00, 1, 1, 0, 1, 0, 0);
        step("R2 line wins",        1, 8'h0F, 1, 1, 0, 1, 0, 0);
        step("R3 rx second",        0, 8'h00, 0, 1, 0, 1, 0, 0);
        step("R5 modem",            0, 8'h00, 0, 0, 0, 1, 0, 0);
        step("R4 R6 arm",           0, 8'h00, 0, 0, 1, 1, 0, 0);
        step("R4 tx over modem",    0, 8'h00, 0, 0, 0, 1, 0, 0);
        step("R7 read other keeps", 0, 8'h00, 0, 1, 0, 1, 0, 1);
        step("R7 still pending",    0, 8'h00, 0, 0, 0, 1, 0, 0);
        step("R7 consume",          0, 8'h00, 0, 0, 0, 1, 0, 1);
        step("R5 none",             0, 8'h00, 0, 0, 0, 0, 0, 0);
        step("R6 masked arm",       1, 8'h00, 0, 0, 1, 0, 0, 0);
        step("R6 masked read",      0, 8'h00, 0, 0, 0, 0, 0, 1);
        step("R6 unmask",           1, 8'h02, 0, 0, 0, 0, 0, 0);
        step("R8 read+write",       0, 8'h00, 0, 0, 1, 0, 0, 1);
        step("R8 kept",             0, 8'h00, 0, 0, 0, 0, 0, 0);
        step("R7 consume again",    0, 8'h00, 0, 0, 0, 0, 0, 1);
        step("R9 queue bits",       0, 8'h00, 0, 0, 0, 0, 1, 0);
        step("R9 queue with rx",    1, 8'h01, 0, 1, 0, 0, 1, 0);
        step("R10 settle",          0, 8'h00, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule